// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block is the host side of a PC-style parallel port. It holds a data byte and a control byte, exposes a read-only status byte, and connects all three to a simple synchronous register bus. The bus has a 2-bit register select, a write strobe, a read strobe and a combinational read-data return. On the pin side it drives eight data lines through a shared output enable and four active-low handshake outputs. It samples the eight data lines and five status inputs through two-flop synchronisers.

The data-line drivers are turned off only when the port runs in an extended mode and the direction bit of the control byte is set. In compatible or nibble operation (mode input low), the written data byte always drives the lines. An interrupt request is raised on a rising edge of the synchronised acknowledge input when the enable bit allows it. The request stays pending until software reads the status byte.

Top module: `pport_regs`

## Requirements
- R1: After reset the control byte is 0x00, the data byte is 0x00 and the data lines are enabled (pd_oe=1). irq is 0. The pins show n_strobe=1, n_autofd=1, n_selectin=1 and n_init=0.
- R2: A write with sel=0 (data) loads wr_data, and pd_out shows the new value from the cycle after the write edge.
- R3: A read with sel=0 returns the level on pd_in as seen through a two-flop synchroniser, so it is valid two clock edges after the pin changes. It does not return the last written byte.
- R4: A read with sel=1 (status) returns the synchronised pins, valid two edges after they change. The bit layout is: bit 7 = inverse of busy_i, bit 6 = n_ack_i, bit 5 = perror_i, bit 4 = select_i, bit 3 = n_fault_i, bits 2..0 = 0.
- R5: A write with sel=2 (control) stores wr_data[5:0]. Bits 7:6 read back as 0. Bit 0 drives n_strobe inverted, bit 1 drives n_autofd inverted, bit 3 drives n_selectin inverted, and bit 2 drives n_init unchanged.
- R6: With ext_mode=1, setting control bit 5 drives pd_oe to 0, and clearing it restores pd_oe to 1.
- R7: With ext_mode=0, pd_oe stays 1 whatever control bit 5 holds, and data writes still reach pd_out.
- R8: With control bit 4 set, a low-to-high change of n_ack_i sets irq three clock edges after the pin change.
- R9: A rising n_ack_i edge while bit 4 is clear, or a falling edge with bit 4 set, leaves irq at 0.
- R10: Once set, irq stays high until a read with sel=1 and rd_en=1, after which it is 0 from the next cycle.
- R11: Writes with sel=1 or sel=3 change no register, and a read with sel=3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Register select: 0 data, 1 status, 2 control, 3 reserved |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (a status read clears the pending interrupt) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational on sel |
| ext_mode | input | 1 | 1 = extended mode, direction bit honoured |
| pd_in | input | 8 | Data line levels from the pad |
| pd_out | output | 8 | Data line drive value |
| pd_oe | output | 1 | Data line driver enable |
| n_strobe | output | 1 | Strobe, active low |
| n_autofd | output | 1 | Auto feed, active low |
| n_init | output | 1 | Initialise, active low |
| n_selectin | output | 1 | Select in, active low |
| busy_i | input | 1 | Busy pin |
| n_ack_i | input | 1 | Acknowledge pin, active low |
| perror_i | input | 1 | Paper error pin |
| select_i | input | 1 | Select pin |
| n_fault_i | input | 1 | Fault pin, active low |
| irq | output | 1 | Pending interrupt request |

## Verification
Register writes take effect on the pins one edge after the write. Pin samples appear in reads two edges after the pin changes. An acknowledge rise raises irq on the third edge, and a status read clears irq on the following edge. The bench changes inputs on the falling clock edge and waits exactly that number of rising edges before sampling on a falling edge. For the interrupt, it also samples one edge early to confirm the result has not arrived before its due cycle.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int BYTE_W = 8;
    localparam int CTRL_W = 6;
    localparam int STAT_W = 5;
    localparam int STAT_PAD = BYTE_W - STAT_W;

    // control bit positions (software-visible layout)
    localparam int CB_STROBE = 0;
    localparam int CB_AUTOFD = 1;
    localparam int CB_INIT   = 2;
    localparam int CB_SELIN  = 3;
    localparam int CB_IEN    = 4;
    localparam int CB_DIR    = 5;

    // status input vector positions inside the synchroniser
    localparam int SI_FAULT = 0;
    localparam int SI_SEL   = 1;
    localparam int SI_PERR  = 2;
    localparam int SI_ACK   = 3;
    localparam int SI_BUSY  = 4;

    typedef enum logic [1:0] {
        SEL_DATA   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_RSVD   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [CTRL_W-1:0] ctrl;
    } host_regs_t;

    typedef struct packed {
        logic prev;
        logic pending;
    } irq_state_t;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/pport_irq.sv
module pport_irq
    import pport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic enable,
    input  logic clear,
    output logic pending
);
    irq_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        rise       = level && !st_q.prev;
        st_d.prev  = level;
        st_d.pending = st_q.pending;
        if (clear)          st_d.pending = 1'b0;
        if (rise && enable) st_d.pending = 1'b1;   // a new edge beats a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pending;
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ext_mode,
    input  logic [BYTE_W-1:0] pd_in,
    output logic [BYTE_W-1:0] pd_out,
    output logic              pd_oe,
    output logic              n_strobe,
    output logic              n_autofd,
    output logic              n_init,
    output logic              n_selectin,
    input  logic              busy_i,
    input  logic              n_ack_i,
    input  logic              perror_i,
    input  logic              select_i,
    input  logic              n_fault_i,
    output logic              irq
);
    host_regs_t        regs_d, regs_q;
    reg_sel_e          sel_e;
    logic [STAT_W-1:0] stat_raw, stat_s;
    logic [BYTE_W-1:0] pins_s;
    logic [BYTE_W-1:0] status_byte;
    logic              stat_clear;

    assign sel_e = reg_sel_e'(sel);

    assign stat_raw[SI_FAULT] = n_fault_i;
    assign stat_raw[SI_SEL]   = select_i;
    assign stat_raw[SI_PERR]  = perror_i;
    assign stat_raw[SI_ACK]   = n_ack_i;
    assign stat_raw[SI_BUSY]  = busy_i;

    pport_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) i_stat_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (stat_raw),
        .dout (stat_s)
    );

    pport_sync #(.WIDTH(BYTE_W), .STAGES(SYNC_STAGES)) i_data_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pd_in),
        .dout (pins_s)
    );

    assign stat_clear = rd_en && (sel_e == SEL_STATUS);

    pport_irq i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (stat_s[SI_ACK]),
        .enable (regs_q.ctrl[CB_IEN]),
        .clear  (stat_clear),
        .pending(irq)
    );

    // register next state
    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (sel_e)
                SEL_DATA: regs_d.data = wr_data;
                SEL_CTRL: regs_d.ctrl = wr_data[CTRL_W-1:0];
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // status byte assembly: busy is presented inverted
    always_comb begin
        status_byte = '0;
        status_byte[STAT_PAD+SI_FAULT] = stat_s[SI_FAULT];
        status_byte[STAT_PAD+SI_SEL]   = stat_s[SI_SEL];
        status_byte[STAT_PAD+SI_PERR]  = stat_s[SI_PERR];
        status_byte[STAT_PAD+SI_ACK]   = stat_s[SI_ACK];
        status_byte[STAT_PAD+SI_BUSY]  = !stat_s[SI_BUSY];
    end

    always_comb begin
        case (sel_e)
            SEL_DATA:   rd_data = pins_s;
            SEL_STATUS: rd_data = status_byte;
            SEL_CTRL:   rd_data = {{(BYTE_W-CTRL_W){1'b0}}, regs_q.ctrl};
            default:    rd_data = '0;
        endcase
    end

    // pin drive
    assign pd_out     = regs_q.data;
    assign pd_oe      = !(ext_mode && regs_q.ctrl[CB_DIR]);
    assign n_strobe   = !regs_q.ctrl[CB_STROBE];
    assign n_autofd   = !regs_q.ctrl[CB_AUTOFD];
    assign n_selectin = !regs_q.ctrl[CB_SELIN];
    assign n_init     = regs_q.ctrl[CB_INIT];
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wr_data,
    input logic       ext_mode,
    input logic [7:0] pd_out,
    input logic       pd_oe,
    input logic       n_strobe,
    input logic       n_init,
    input logic       irq
);
    assert_compat_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> pd_oe);

    assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd0) |=> (pd_out == $past(wr_data)));

    assert_ctrl_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd2) |=> (n_strobe == !$past(wr_data[0]) && n_init == $past(wr_data[2])));

    assert_dir_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd2 && wr_data[5] && ext_mode) |=> (!pd_oe || !ext_mode));

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_en && sel == 2'd1));
endmodule

bind pport_regs pport_regs_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_data (wr_data),
    .ext_mode(ext_mode),
    .pd_out  (pd_out),
    .pd_oe   (pd_oe),
    .n_strobe(n_strobe),
    .n_init  (n_init),
    .irq     (irq)
);

// File: tb/test_pport_regs.sv
module test_pport_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ext_mode = 1'b0;
    logic [7:0] pd_in = 8'h00;
    logic [7:0] pd_out;
    logic       pd_oe, n_strobe, n_autofd, n_init, n_selectin;
    logic       busy_i = 1'b0, n_ack_i = 1'b1, perror_i = 1'b0, select_i = 1'b0, n_fault_i = 1'b1;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_regs i_pport_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .ext_mode(ext_mode),
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .n_strobe(n_strobe), .n_autofd(n_autofd), .n_init(n_init), .n_selectin(n_selectin),
        .busy_i(busy_i), .n_ack_i(n_ack_i), .perror_i(perror_i),
        .select_i(select_i), .n_fault_i(n_fault_i), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        sel = s; wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 pd_out", pd_out, 8'h00);
        chk("R1 pd_oe", {7'd0, pd_oe}, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 pins", {4'd0, n_strobe, n_autofd, n_selectin, n_init}, 8'h0E);
        read_reg(2'd2, v);
        chk("R1 ctrl", v, 8'h00);
    endtask

    task automatic t_data_write;
        write_reg(2'd0, 8'hA5);
        chk("R2 pd_out A5", pd_out, 8'hA5);
        write_reg(2'd0, 8'h3C);
        chk("R2 pd_out 3C", pd_out, 8'h3C);
    endtask

    task automatic t_data_read;
        logic [7:0] v;
        @(negedge clk);
        pd_in = 8'h5A;
        wait_edges(2);
        #1 sel = 2'd0;
        #1 chk("R3 pin read", rd_data, 8'h5A);
        read_reg(2'd0, v);
        chk("R3 not last write", v, 8'h5A);
    endtask

    task automatic t_status;
        logic [7:0] v;
        @(negedge clk);
        busy_i = 1; n_ack_i = 0; perror_i = 1; select_i = 0; n_fault_i = 1;
        wait_edges(2);
        read_reg(2'd1, v);
        chk("R4 status 28", v, 8'h28);
        busy_i = 0; n_ack_i = 1; perror_i = 0; select_i = 1; n_fault_i = 0;
        wait_edges(2);
        read_reg(2'd1, v);
        chk("R4 status D0", v, 8'hD0);
    endtask

    task automatic t_ctrl;
        logic [7:0] v;
        write_reg(2'd2, 8'h0F);
        chk("R5 pins 0F", {4'd0, n_strobe, n_autofd, n_selectin, n_init}, 8'h01);
        read_reg(2'd2, v);
        chk("R5 read 0F", v, 8'h0F);
        write_reg(2'd2, 8'hC4);
        chk("R5 pins C4", {4'd0, n_strobe, n_autofd, n_selectin, n_init}, 8'h0F);
        read_reg(2'd2, v);
        chk("R5 read C4", v, 8'h04);
    endtask

    task automatic t_dir;
        ext_mode = 1'b1;
        write_reg(2'd2, 8'h20);
        chk("R6 oe off", {7'd0, pd_oe}, 8'h00);
        write_reg(2'd2, 8'h00);
        chk("R6 oe on", {7'd0, pd_oe}, 8'h01);
    endtask

    task automatic t_compat;
        ext_mode = 1'b0;
        write_reg(2'd2, 8'h20);
        chk("R7 oe kept", {7'd0, pd_oe}, 8'h01);
        write_reg(2'd0, 8'h77);
        chk("R7 data drives", pd_out, 8'h77);
        chk("R7 oe still", {7'd0, pd_oe}, 8'h01);
        write_reg(2'd2, 8'h00);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        write_reg(2'd2, 8'h10);
        n_ack_i = 1'b0;
        wait_edges(4);
        read_reg(2'd1, v);
        chk("R8 idle", {7'd0, irq}, 8'h00);
        n_ack_i = 1'b1;          // changed on a falling edge
        wait_edges(2);
        chk("R8 not early", {7'd0, irq}, 8'h00);
        wait_edges(1);
        chk("R8 irq set", {7'd0, irq}, 8'h01);
        wait_edges(5);
        chk("R10 sticky", {7'd0, irq}, 8'h01);
        read_reg(2'd1, v);
        chk("R10 cleared", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_noirq;
        write_reg(2'd2, 8'h00);
        n_ack_i = 1'b0;
        wait_edges(4);
        n_ack_i = 1'b1;
        wait_edges(5);
        chk("R9 disabled rise", {7'd0, irq}, 8'h00);
        write_reg(2'd2, 8'h10);
        n_ack_i = 1'b0;
        wait_edges(5);
        chk("R9 falling edge", {7'd0, irq}, 8'h00);
        n_ack_i = 1'b1;
        wait_edges(4);
        write_reg(2'd2, 8'h00);
    endtask

    task automatic t_ignored;
        logic [7:0] v;
        logic [7:0] st;
        write_reg(2'd2, 8'h0A);
        read_reg(2'd1, st);
        write_reg(2'd1, 8'hFF);
        write_reg(2'd3, 8'hFF);
        read_reg(2'd2, v);
        chk("R11 ctrl kept", v, 8'h0A);
        chk("R11 data kept", pd_out, 8'h77);
        read_reg(2'd1, v);
        chk("R11 status kept", v, st);
        read_reg(2'd3, v);
        chk("R11 rsvd zero", v, 8'h00);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_write();
        t_data_read();
        t_status();
        t_ctrl();
        t_dir();
        t_compat();
        t_irq();
        t_noirq();
        t_ignored();
        finish_run();
    end
endmodule